// File: doc/BRIEF.md
# Eight-Pin General-Purpose I/O Port

This block is one general-purpose I/O port of eight pins, reached through a small register bus. The bus has an address, a write strobe, write data and read data. A write takes effect at the rising clock edge where the strobe is high. Read data is a combinational function of the address and the current state, so it is valid in the same cycle as the address.

Each pin has a direction bit and an output data bit. Each pin also has an assignment bit that gives the pad either to the port itself or to a primary peripheral function. The pad appears as three separate signals: an input level, a driven level and a drive enable.

Software works on the output bits in two ways. It can write the whole output register at once. It can also set or clear single bits through two dedicated addresses. The set address doubles as the pin-level read address, and the levels it returns have passed through a two-stage synchronizer. The port has no interrupt output.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction, output data and assignment registers are all zero, so every pad has its drive enable low and every pin is a port input.
- R2: For a pin whose assignment bit is 0, the pad drive enable equals its direction bit (1 means output), and the driven pad level equals its output data bit.
- R3: Address 1 holds the output data register. A write there loads all eight bits, and a read returns the stored value whatever level is on the pads.
- R4: A read of address 2 returns the synchronized pad level of every port-owned pin, whether that pin is an input or an output. For pins given to the peripheral it returns 0.
- R5: A write to address 2 sets each output data bit whose write-data bit is 1. Bits written as 0 keep their value.
- R6: A write to address 3 clears each output data bit whose write-data bit is 0. Bits written as 1 keep their value. A read of address 3 returns zero.
- R7: Address 4 holds the assignment register, and it reads back as written. A pin whose bit is 1 takes its pad drive level and drive enable from the peripheral inputs instead of from the port registers.
- R8: A pad level change becomes visible at address 2 after exactly two rising clock edges, and not after the first.
- R9: Address 0 holds the direction register, and it reads back as written. Addresses 5 to 7 read as zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| we | input | 1 | Write strobe |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for the current address |
| pad_in | input | 8 | Level present on each pad |
| pad_out | output | 8 | Level driven onto each pad |
| pad_oe | output | 8 | Drive enable for each pad |
| alt_out | input | 8 | Peripheral drive level for each pin |
| alt_oe | input | 8 | Peripheral drive enable for each pin |
| alt_in | output | 8 | Pad level passed to the peripheral |

## Verification
The bench targets the inverted bit senses of the set and clear addresses. A design that swapped them would clear bits on a set write, or clear the wrong bits on a clear write, and the readback of address 1 would then be wrong.

It checks that the pin-level read masks out pins given to the peripheral. It also checks that peripheral signals reach only the pads whose assignment bit is 1. A wrong mask would show up as a pad driven from the wrong source, or as a nonzero read of a peripheral-owned pin.

It counts the synchronizer latency edge by edge. A design with one stage or with three stages would show the new pad level one cycle too early or one cycle too late.

Finally, it writes to an unmapped address and reads it back. A design that decoded only the low address bits would then corrupt a real register.

// File: rtl/gpio_port.sv
module gpio_port #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    addr,
  input  logic             we,
  input  logic [WIDTH-1:0] wdata,
  output logic [WIDTH-1:0] rdata,
  input  logic [WIDTH-1:0] pad_in,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic [WIDTH-1:0] alt_in
);
  localparam logic [AW-1:0] A_DIR = 0, A_OUT = 1, A_PIN = 2, A_CLR = 3, A_ASG = 4;

  logic [WIDTH-1:0] dir_q, out_q, asg_q, meta_q, pin_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
      out_q <= '0;
      asg_q <= '0;
    end else if (we) begin
      case (addr)
        A_DIR:   dir_q <= wdata;
        A_OUT:   out_q <= wdata;
        A_PIN:   out_q <= out_q | wdata;
        A_CLR:   out_q <= out_q & wdata;
        A_ASG:   asg_q <= wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      pin_q  <= '0;
    end else begin
      meta_q <= pad_in;
      pin_q  <= meta_q;
    end
  end

  always_comb begin
    case (addr)
      A_DIR:   rdata = dir_q;
      A_OUT:   rdata = out_q;
      A_PIN:   rdata = pin_q & ~asg_q;
      A_ASG:   rdata = asg_q;
      default: rdata = '0;
    endcase
  end

  assign pad_out = (asg_q & alt_out) | (~asg_q & out_q);
  assign pad_oe  = (asg_q & alt_oe)  | (~asg_q & dir_q);
  assign alt_in  = pad_in;
endmodule

module gpio_port_chk #(
  parameter int WIDTH = 8,
  parameter int AW    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    addr,
  input logic             we,
  input logic [WIDTH-1:0] wdata,
  input logic [WIDTH-1:0] rdata,
  input logic [WIDTH-1:0] pad_in,
  input logic [WIDTH-1:0] out_q,
  input logic [WIDTH-1:0] asg_q
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) age <= '0;
    else if (age != 2'd3) age <= age + 2'd1;

  a_r5_set_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(2)) |=> out_q == ($past(out_q) | $past(wdata)));

  a_r6_clear_bits: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == AW'(3)) |=> out_q == ($past(out_q) & $past(wdata)));

  a_r6_clear_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    addr == AW'(3) |-> rdata == '0);

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(out_q));

  a_r8_two_stage_sync: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && addr == AW'(2)) |-> rdata == ($past(pad_in, 2) & ~asg_q));

  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (addr > AW'(4)) |-> rdata == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
  .rdata(rdata), .pad_in(pad_in), .out_q(out_q), .asg_q(asg_q));

// File: tb/gpio_port_bench.sv
module gpio_port_bench;
  logic       clk = 0, rst_n = 0, we = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pad_in = 0, alt_out = 0, alt_oe = 0;
  logic [7:0] rdata, pad_out, pad_oe, alt_in;
  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  gpio_port u_gpio_port (.clk(clk), .rst_n(rst_n), .addr(addr), .we(we), .wdata(wdata),
    .rdata(rdata), .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
    .alt_out(alt_out), .alt_oe(alt_oe), .alt_in(alt_in));

  // {we, addr, data}: on writes data is written, on reads it is the expected rdata
  localparam int NV = 15;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 3'd0, 8'h0F},  // R9 dir
    {1'b1, 3'd1, 8'h3C},  // R3
    {1'b0, 3'd1, 8'h3C},  // R3
    {1'b0, 3'd0, 8'h0F},  // R9
    {1'b1, 3'd2, 8'h81},  // R5
    {1'b0, 3'd1, 8'hBD},  // R5
    {1'b1, 3'd3, 8'hF0},  // R6
    {1'b0, 3'd1, 8'hB0},  // R6
    {1'b0, 3'd3, 8'h00},  // R6
    {1'b1, 3'd4, 8'hC0},  // R7
    {1'b0, 3'd4, 8'hC0},  // R7
    {1'b0, 3'd2, 8'h25},  // R4
    {1'b1, 3'd5, 8'hFF},  // R9
    {1'b0, 3'd5, 8'h00},  // R9
    {1'b0, 3'd1, 8'hB0}   // R9
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; we = 1;
    @(negedge clk); we = 0;
  endtask

  task automatic rd(input string req, input logic [2:0] a, input logic [7:0] exp);
    @(negedge clk); addr = a; we = 0; #1;
    check(req, rdata, exp);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_vec++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    pad_in = 8'hA5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    check("R1 oe", pad_oe, 8'h00);
    rd("R1 dir", 3'd0, 8'h00);
    rd("R1 out", 3'd1, 8'h00);
    rd("R1 asg", 3'd4, 8'h00);

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][11]) wr(VEC[i][10:8], VEC[i][7:0]);
      else rd($sformatf("vec%0d", i), VEC[i][10:8], VEC[i][7:0]);
    end

    // R7 / R2 pad muxing: dir=0F, out=B0, asg=C0
    @(negedge clk); alt_out = 8'h5A; alt_oe = 8'hF0; #1;
    check("R7 oe", pad_oe, 8'hCF);
    check("R2 out", pad_out, 8'h70);
    check("R2 alt_in", alt_in, 8'hA5);

    // R8 synchronizer latency
    wr(3'd4, 8'h00);
    @(negedge clk); addr = 3'd2; pad_in = 8'h3C; #1;
    check("R8 edge0", rdata, 8'hA5);
    @(negedge clk); #1;
    check("R8 edge1", rdata, 8'hA5);
    @(negedge clk); #1;
    check("R8 edge2", rdata, 8'h3C);
    // R4 output pins also read their pad level
    check("R4 out pin", rdata & 8'h0F, 8'h0C);

    // R1 reset mid-run
    @(negedge clk); rst_n = 0; #1;
    check("R1 oe again", pad_oe, 8'h00);
    @(negedge clk); rst_n = 1;
    rd("R1 out again", 3'd1, 8'h00);
    finish_run();
  end
endmodule